// File: doc/BRIEF.md
# Synchronous Register Bus Slave

This block is the slave side of a synchronous host bus that reaches a small internal register file. The host drives an active-low select, an address and a direction bit. All three are sampled on a rising clock edge while the port is idle. The port then runs a fixed schedule. One edge later it either captures the write data or drives the read data. In the cycle that follows that edge it returns an active-low ready pulse that lasts exactly one clock.

The shared data bus is modelled as three signals: data in, data out and an output enable. The output enable stays low in the cycle right after the sampling edge, so the device that drove the bus in the previous access has time to release it. Read data stays on the bus while the host holds select. It is removed at the second rising edge after select is seen released.

One register is a long-latency data register. Accesses to it wait a parameterised number of extra cycles before ready is given. A separate asynchronous strobe input is accepted and has no effect.

Top module: `regbus_slave`

## Requirements
- R1: An access starts when cs_ni is sampled low at a rising edge while the port is idle. rd_wr_i sampled high at that edge means read; low means write.
- R2: For a normal register, rdy_no is low, data_oe_o is high and data_o holds the register value in the cycle after the first rising edge that follows the sampling edge.
- R3: data_oe_o is low in the cycle after the sampling edge, and it never goes high during a write.
- R4: Write data on data_i is stored at the same edge at which ready is produced. A later read of that address returns the stored value.
- R5: rdy_no is low for exactly one clock per access, however long select is held.
- R6: During a read, data_oe_o stays high and data_o stays stable until the second rising edge at which cs_ni is sampled high. data_oe_o is low after that edge.
- R7: Address SLOW_ADDR (default 9) defers ready, and the read-data drive or write capture, by SLOW_EXTRA cycles (default 3). SLOW_EXTRA = 0 behaves like a normal register.
- R8: While cs_ni stays low after ready, no new access is recognised. A new access needs cs_ni high for two rising edges.
- R9: strobe_ni has no effect on any output.
- R10: Addresses from NUM_REGS (default 10) upward are unmapped. A read of such an address returns zero with a single ready pulse, and a write to it changes no register.
- R11: After reset, rdy_no is high, data_oe_o is low, data_o is zero and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| addr_i | input | ADDR_W | Register address |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| strobe_ni | input | 1 | Asynchronous data strobe, ignored |
| data_i | input | DATA_W | Write data from the bus |
| data_o | output | DATA_W | Read data to the bus |
| data_oe_o | output | 1 | Data bus output enable |
| rdy_no | output | 1 | Ready, active low, one-cycle pulse |

## Verification
The hardest case to reach is a slow-register access in which the host holds select well past ready. Ready must still be one cycle long, no second access may start, the bus must stay driven and stable, and release must happen exactly two edges after select goes high. The stimulus mixes random addresses, which include the slow and unmapped ones, with random hold lengths and random strobe activity. It is preceded by directed write-then-readback passes over every address. Each cycle of each access is compared against a bench model of the schedule.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SLOW,
    ST_HOLD,
    ST_RELEASE
  } bus_state_e;
endpackage

// File: rtl/regbus_seq.sv
module regbus_seq
  import regbus_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int SLOW_EXTRA = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_wr_i,
  input  logic              slow_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic              rd_q_o,
  output logic              start_o,
  output logic              done_o,
  output logic              release_o
);
  localparam int CNT_W = (SLOW_EXTRA > 0) ? $clog2(SLOW_EXTRA + 1) : 1;
  localparam int LOAD  = (SLOW_EXTRA > 0) ? SLOW_EXTRA - 1 : 0;
  localparam bit HAS_SLOW = (SLOW_EXTRA > 0);

  bus_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;

  assign start_o   = (state_q == ST_IDLE) && !cs_ni;
  assign done_o    = ((state_q == ST_SETUP) && !(slow_i && HAS_SLOW)) ||
                     ((state_q == ST_SLOW) && (cnt_q == '0));
  assign release_o = (state_q == ST_RELEASE);
  assign addr_q_o  = addr_q;
  assign rd_q_o    = rd_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:    if (!cs_ni) state_d = ST_SETUP;
      ST_SETUP: begin
        if (slow_i && HAS_SLOW) begin
          state_d = ST_SLOW;
          cnt_d   = CNT_W'(LOAD);
        end else begin
          state_d = ST_HOLD;
        end
      end
      ST_SLOW: begin
        if (cnt_q == '0) state_d = ST_HOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_HOLD:    if (cs_ni) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (start_o) begin
        addr_q <= addr_i;
        rd_q   <= rd_wr_i;
      end
    end
  end
endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= '0;
      else if (we_i && (addr_i == ADDR_W'(g)))     regs_q[g] <= wdata_i;
    end
  end

  // unmapped addresses fall through to zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = regs_q[i];
    end
  end
endmodule

// File: rtl/regbus_drv.sv
module regbus_drv #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              rd_i,
  input  logic              release_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rdy_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_no    <= 1'b1;
      data_oe_o <= 1'b0;
      data_o    <= '0;
    end else begin
      rdy_no <= !done_i;
      if (done_i && rd_i) begin
        data_oe_o <= 1'b1;
        data_o    <= rdata_i;
      end else if (release_i) begin
        data_oe_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regbus_slave.sv
module regbus_slave #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 10,
  parameter int SLOW_ADDR  = 9,
  parameter int SLOW_EXTRA = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_wr_i,
  input  logic              strobe_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rdy_no
);
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, start_w, done_w, release_w, slow_w, we_w;
  logic [DATA_W-1:0] rdata_w;
  logic              unused_strobe;

  assign unused_strobe = strobe_ni;  // R9: asynchronous strobe has no role here
  assign slow_w        = (addr_q == ADDR_W'(SLOW_ADDR));
  assign we_w          = done_w && !rd_q;

  regbus_seq #(.ADDR_W(ADDR_W), .SLOW_EXTRA(SLOW_EXTRA)) u_seq (
    .clk_i, .rst_ni, .cs_ni, .addr_i, .rd_wr_i,
    .slow_i   (slow_w),
    .addr_q_o (addr_q),
    .rd_q_o   (rd_q),
    .start_o  (start_w),
    .done_o   (done_w),
    .release_o(release_w)
  );

  regbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk_i, .rst_ni,
    .we_i   (we_w),
    .addr_i (addr_q),
    .wdata_i(data_i),
    .rdata_o(rdata_w)
  );

  regbus_drv #(.DATA_W(DATA_W)) u_drv (
    .clk_i, .rst_ni,
    .done_i   (done_w),
    .rd_i     (rd_q),
    .release_i(release_w),
    .rdata_i  (rdata_w),
    .data_o, .data_oe_o, .rdy_no
  );
endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              start_w,
  input logic              rd_q,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              rdy_no
);
  AST_RDY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |=> rdy_no);  // R5

  AST_OE_DELAYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> !data_oe_o);  // R3

  AST_OE_WITH_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> !rdy_no);  // R2

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_no && !rd_q) |-> !data_oe_o);  // R3

  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));  // R6

  AST_BUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !cs_ni && !$past(cs_ni)) |=> data_oe_o);  // R6
endmodule

bind regbus_slave regbus_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .start_w  (start_w),
  .rd_q     (rd_q),
  .data_o   (data_o),
  .data_oe_o(data_oe_o),
  .rdy_no   (rdy_no)
);

// File: tb/regbus_slave_test.sv
`timescale 1ns/1ps
module regbus_slave_test;
  localparam int ADDR_W = 4, DATA_W = 16, NUM_REGS = 10;
  localparam int SLOW_ADDR = 9, SLOW_EXTRA = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b1, strobe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0, dout;
  logic oe, rdy_n;

  int total = 0, fails = 0;
  logic [DATA_W-1:0] model [NUM_REGS];

  always #5 clk = ~clk;

  regbus_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
                 .SLOW_ADDR(SLOW_ADDR), .SLOW_EXTRA(SLOW_EXTRA)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .addr_i(addr), .rd_wr_i(rw),
    .strobe_ni(strobe_n), .data_i(din), .data_o(dout), .data_oe_o(oe), .rdy_no(rdy_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_rd(input logic [ADDR_W-1:0] a);
    return (int'(a) < NUM_REGS) ? model[a] : '0;
  endfunction

  // called at a negedge with the port idle; returns at a negedge with the port idle
  task automatic access(input bit rd, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input int hold);
    logic [DATA_W-1:0] e;
    int lat;
    string rq;
    e   = exp_rd(a);
    lat = (int'(a) == SLOW_ADDR) ? SLOW_EXTRA : 0;
    rq  = (lat > 0) ? "R7" : ((int'(a) >= NUM_REGS) ? "R10" : "R2");
    cs_n = 1'b0; rw = rd; addr = a; din = d; strobe_n = 1'($urandom);
    @(negedge clk);
    chk(oe == 1'b0, "R3", "oe after sampling edge", 32'(oe), 0);
    chk(rdy_n == 1'b1, "R1", "rdy before schedule", 32'(rdy_n), 1);
    for (int i = 0; i < lat; i++) begin
      strobe_n = 1'($urandom);
      @(negedge clk);
      chk(rdy_n == 1'b1 && oe == 1'b0, "R7", "slow wait rdy/oe", {rdy_n, oe}, 32'b10);
    end
    @(negedge clk);
    chk(rdy_n == 1'b0, rq, "ready pulse", 32'(rdy_n), 0);
    if (rd) begin
      chk(oe == 1'b1, rq, "oe with ready", 32'(oe), 1);
      chk(dout == e, rq, "read data", 32'(dout), 32'(e));
    end else begin
      chk(oe == 1'b0, "R3", "oe on write", 32'(oe), 0);
      if (int'(a) < NUM_REGS) model[a] = d;  // R4
    end
    for (int i = 0; i < hold; i++) begin
      strobe_n = 1'($urandom);
      @(negedge clk);
      chk(rdy_n == 1'b1, "R8", "no re-trigger while held", 32'(rdy_n), 1);
      chk(oe == rd, "R6", "oe while held", 32'(oe), 32'(rd));
      if (rd) chk(dout == e, "R6", "data held", 32'(dout), 32'(e));
    end
    cs_n = 1'b1;
    @(negedge clk);
    chk(rdy_n == 1'b1, "R5", "ready single cycle", 32'(rdy_n), 1);
    chk(oe == rd, "R6", "oe one edge after release", 32'(oe), 32'(rd));
    @(negedge clk);
    chk(oe == 1'b0, "R6", "oe two edges after release", 32'(oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_n == 1'b1 && oe == 1'b0 && dout == '0, "R11", "reset outputs",
        {rdy_n, oe, dout}, {2'b10, 16'h0});
    for (int a = 0; a < NUM_REGS; a++) access(1'b1, ADDR_W'(a), '0, 0);  // R11 registers zero

    // R9: strobe activity while idle does nothing
    for (int i = 0; i < 6; i++) begin
      strobe_n = ~strobe_n;
      @(negedge clk);
      chk(rdy_n == 1'b1 && oe == 1'b0, "R9", "strobe while idle", {rdy_n, oe}, 32'b10);
    end

    // R4 directed write then readback over every address, incl. slow and unmapped
    for (int a = 0; a < (1 << ADDR_W); a++)
      access(1'b0, ADDR_W'(a), DATA_W'(16'hA500 + a), a % 3);
    for (int a = 0; a < (1 << ADDR_W); a++)
      access(1'b1, ADDR_W'(a), '0, a % 4);  // R4 / R10

    // R8 long hold on slow register
    access(1'b1, ADDR_W'(SLOW_ADDR), '0, 7);
    access(1'b0, ADDR_W'(SLOW_ADDR), 16'h5A5A, 6);
    access(1'b1, ADDR_W'(SLOW_ADDR), '0, 0);

    // random mix
    for (int n = 0; n < 120; n++)
      access(1'($urandom), ADDR_W'($urandom), DATA_W'($urandom), int'($urandom % 4));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule